// File: doc/BRIEF.md
# Spread-Spectrum Divide-Ratio Sweep Generator

This block feeds the feedback divider of a fractional-N clock synthesizer. On every reference clock cycle it presents a divide ratio as an integer part and a binary fraction. The ratio is swept in a symmetric triangle from 1% below to 1% above a nominal value. This spreads the synthesized clock's energy over a band and lowers its spectral peaks, while the average output frequency stays exactly on target. The reference is nominally 14.31818 MHz and the sweep repeats at about 40 kHz.

There are two channels. The main channel always runs at a nominal 120 MHz. The auxiliary channel targets 72 MHz or 48 MHz, chosen by a select input. It can be frozen by an enable input: while disabled, its sweep stops and its output holds. A new select value is only adopted when the auxiliary sweep begins a new period, so the ratio never jumps in the middle of a sweep.

Each sweep is generated by an error-accumulating stepper. Every step adds the integer quotient of the total swing, plus one extra LSB whenever the accumulated remainder overflows. The slopes therefore end exactly on the extremes, and the falling half mirrors the rising half.

Top module: `spread_mod_gen`

## Requirements
- R1: Each output is the value `nominal + offset` in unsigned fixed point, with an INT_W-bit integer part and a FRAC_W-bit fraction (defaults 8 and 24). Here `nominal = round(F * 2^FRAC_W / REF)`. F is 120 MHz on the main channel. On the auxiliary channel F is 72 MHz for select 0 and 48 MHz for select 1.
- R2: The offset amplitude is `A = round(nominal / 100)`. In each period the offset reaches exactly -A once and exactly +A once, and it never leaves [-A, +A].
- R3: One period lasts `P = 2H` reference cycles, where `H = floor(round(REF / MOD) / 2)`. With the defaults H = 179 and P = 358.
- R4: Counting from the period start (index 0, offset -A), sample i in 0..H has offset `-A + floor(i*2A/H)`. Sample H+j (j in 0..H-1) has offset `A - floor(j*2A/H)`. Each step changes the value by `floor(2A/H)` or one more, upward on the rising half and downward on the falling half.
- R5: Sample H+j and sample j of the same period add up to exactly `2 * nominal`.
- R6: The sum of the P samples of one period equals exactly `P * nominal`.
- R7: The output during reset, and on the first sample after it, is sample index `(H-1)/2` of the rising half. This is the rising point nearest the nominal value.
- R8: While the auxiliary enable is low, the auxiliary output and its sweep position hold. After re-enable the next sample is the successor of the held one. The main channel is not affected.
- R9: A change of the auxiliary select takes effect on the first sample of the next auxiliary period, which equals `nominal_new - A_new`. Every sample before it follows the old profile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ch2_en | input | 1 | Auxiliary channel run enable; low freezes the sweep |
| ch2_sel | input | 1 | Auxiliary target: 0 selects 72 MHz, 1 selects 48 MHz |
| ch1_int | output | INT_W | Main channel divide ratio, integer part |
| ch1_frac | output | FRAC_W | Main channel divide ratio, fractional part |
| ch2_int | output | INT_W | Auxiliary channel divide ratio, integer part |
| ch2_frac | output | FRAC_W | Auxiliary channel divide ratio, fractional part |

## Verification
The assertions assume that `ch2_en` and `ch2_sel` are synchronous to the reference clock. They also assume that reset is held for at least one edge, so that the phase counter and accumulator start from their defined points. The stimulus changes these inputs only on falling clock edges. It toggles the select both mid-sweep and while the channel is frozen, and it samples every output cycle against a closed-form model of the triangle. Extremes, symmetry and period sums are then checked over each full period collected.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  // Integer division with round-half-up.
  function automatic longint div_round(longint n, longint d);
    return (n + d / 2) / d;
  endfunction

  // Nominal divide ratio F/REF in fixed point with fw fraction bits.
  function automatic longint ratio_fx(longint f, longint rf, int fw);
    return div_round(f << fw, rf);
  endfunction

  // Steps per half sweep.
  function automatic int half_len(longint rf, longint md);
    return int'(div_round(rf, md) / 2);
  endfunction

  // Rising-slope index used as the post-reset starting point.
  function automatic int start_k(int h);
    return (h - 1) / 2;
  endfunction

  function automatic longint start_off(longint amp, int h);
    longint q, r, k;
    q = (2 * amp) / h;
    r = (2 * amp) % h;
    k = longint'(start_k(h));
    return -amp + k * q + (k * r) / h;
  endfunction

  function automatic longint start_acc(longint amp, int h);
    longint r, k;
    r = (2 * amp) % h;
    k = longint'(start_k(h));
    return (k * r) % h;
  endfunction

endpackage

// File: rtl/ssm_phase.sv
module ssm_phase #(
  parameter int HALF = 179,
  parameter int KW   = $clog2(2 * HALF)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [KW-1:0] k_nx,
  output logic          wrap_nx
);
  localparam logic [KW-1:0] LAST_K  = KW'(2 * HALF - 1);
  localparam logic [KW-1:0] START_K = KW'(ssm_pkg::start_k(HALF));

  logic [KW-1:0] k_q;

  always_comb begin
    wrap_nx = adv && (k_q == LAST_K);
    if (!adv)        k_nx = k_q;
    else if (wrap_nx) k_nx = '0;
    else             k_nx = k_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) k_q <= START_K;
    else     k_q <= k_nx;
  end

  assert_phase_range_R3: assert property (@(posedge clk) disable iff (rst)
    k_q <= LAST_K);
  assert_phase_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && k_q == LAST_K) |=> (k_q == '0));
  assert_phase_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(k_q));

endmodule

// File: rtl/ssm_tri_dda.sv
module ssm_tri_dda #(
  parameter int     HALF = 179,
  parameter int     KW   = $clog2(2 * HALF),
  parameter int     OW   = 32,
  parameter longint AMP0 = 1406080,
  parameter longint AMP1 = 1406080
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic [KW-1:0]        k_nx,
  input  logic                 sel,
  input  logic                 sel_rst,
  output logic signed [OW-1:0] off_nx
);
  localparam logic [KW-1:0] HALF_K = KW'(HALF);
  localparam logic signed [OW-1:0] AMP_V [2] = '{OW'(AMP0), OW'(AMP1)};
  localparam logic signed [OW-1:0] Q_V   [2] = '{OW'((2 * AMP0) / HALF), OW'((2 * AMP1) / HALF)};
  localparam logic [KW-1:0]        R_V   [2] = '{KW'((2 * AMP0) % HALF), KW'((2 * AMP1) % HALF)};
  localparam logic signed [OW-1:0] OFF0_V[2] = '{OW'(ssm_pkg::start_off(AMP0, HALF)),
                                               OW'(ssm_pkg::start_off(AMP1, HALF))};
  localparam logic [KW-1:0]        ACC0_V[2] = '{KW'(ssm_pkg::start_acc(AMP0, HALF)),
                                               KW'(ssm_pkg::start_acc(AMP1, HALF))};
  localparam logic signed [OW-1:0] AMP_MAX = (AMP0 > AMP1) ? OW'(AMP0) : OW'(AMP1);

  logic signed [OW-1:0] off_q;
  logic [KW-1:0]        acc_q, acc_nx, acc_step;
  logic [KW:0]          sum_w;
  logic                 carry;
  logic signed [OW-1:0] delta;

  always_comb begin
    sum_w    = {1'b0, acc_q} + {1'b0, R_V[sel]};
    carry    = (sum_w >= {1'b0, HALF_K});
    acc_step = carry ? KW'(sum_w - {1'b0, HALF_K}) : sum_w[KW-1:0];
    delta    = Q_V[sel] + OW'(carry);
    off_nx   = off_q;
    acc_nx   = acc_q;
    if (adv) begin
      if (k_nx == '0) begin
        off_nx = -AMP_V[sel];
        acc_nx = '0;
      end else if (k_nx == HALF_K) begin
        off_nx = AMP_V[sel];
        acc_nx = '0;
      end else if (k_nx < HALF_K) begin
        off_nx = off_q + delta;
        acc_nx = acc_step;
      end else begin
        off_nx = off_q - delta;
        acc_nx = acc_step;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q <= OFF0_V[sel_rst];
      acc_q <= ACC0_V[sel_rst];
    end else begin
      off_q <= off_nx;
      acc_q <= acc_nx;
    end
  end

  assert_offset_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (off_q <= AMP_MAX) && (off_q >= -AMP_MAX));
  assert_rise_step_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && k_nx != '0 && k_nx < HALF_K) |=> (off_q > $past(off_q)));
  assert_fall_step_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && k_nx > HALF_K) |=> (off_q < $past(off_q)));
  assert_acc_range_R4: assert property (@(posedge clk) disable iff (rst)
    acc_q < HALF_K);

endmodule

// File: rtl/ssm_channel.sv
module ssm_channel #(
  parameter int     INT_W      = 8,
  parameter int     FRAC_W     = 24,
  parameter longint REF_HZ     = 14318180,
  parameter longint MOD_HZ     = 40000,
  parameter longint F0_HZ      = 72000000,
  parameter longint F1_HZ      = 48000000,
  parameter int     SPREAD_DIV = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sel,
  output logic [INT_W-1:0]  div_int,
  output logic [FRAC_W-1:0] div_frac
);
  localparam int     DW   = INT_W + FRAC_W;
  localparam int     HALF = ssm_pkg::half_len(REF_HZ, MOD_HZ);
  localparam int     KW   = $clog2(2 * HALF);
  localparam longint NOM0 = ssm_pkg::ratio_fx(F0_HZ, REF_HZ, FRAC_W);
  localparam longint NOM1 = ssm_pkg::ratio_fx(F1_HZ, REF_HZ, FRAC_W);
  localparam longint AMP0 = ssm_pkg::div_round(NOM0, SPREAD_DIV);
  localparam longint AMP1 = ssm_pkg::div_round(NOM1, SPREAD_DIV);
  localparam logic [DW-1:0] NOM_V [2] = '{DW'(NOM0), DW'(NOM1)};
  localparam logic [DW-1:0] VAL0_V[2] = '{DW'(NOM0 + ssm_pkg::start_off(AMP0, HALF)),
                                         DW'(NOM1 + ssm_pkg::start_off(AMP1, HALF))};

  logic                 asel_q, asel_nx;
  logic [KW-1:0]        k_nx;
  logic                 wrap_nx;
  logic signed [DW-1:0] off_nx;
  logic [DW-1:0]        val_q, val_nx;

  ssm_phase #(.HALF(HALF), .KW(KW)) u_phase (
    .clk(clk), .rst(rst), .adv(en), .k_nx(k_nx), .wrap_nx(wrap_nx)
  );

  assign asel_nx = wrap_nx ? sel : asel_q;

  ssm_tri_dda #(.HALF(HALF), .KW(KW), .OW(DW), .AMP0(AMP0), .AMP1(AMP1)) u_dda (
    .clk(clk), .rst(rst), .adv(en), .k_nx(k_nx), .sel(asel_nx),
    .sel_rst(sel), .off_nx(off_nx)
  );

  assign val_nx = NOM_V[asel_nx] + $unsigned(off_nx);

  always_ff @(posedge clk) begin
    if (rst) begin
      asel_q <= sel;
      val_q  <= VAL0_V[sel];
    end else begin
      asel_q <= asel_nx;
      val_q  <= val_nx;
    end
  end

  assign div_int  = val_q[DW-1:FRAC_W];
  assign div_frac = val_q[FRAC_W-1:0];

  assert_hold_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(val_q));
  assert_sel_at_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    !wrap_nx |=> $stable(asel_q));

endmodule

// File: rtl/spread_mod_gen.sv
module spread_mod_gen #(
  parameter int     INT_W       = 8,
  parameter int     FRAC_W      = 24,
  parameter longint REF_HZ      = 14318180,
  parameter longint MOD_HZ      = 40000,
  parameter longint MAIN_HZ     = 120000000,
  parameter longint AUX_SEL0_HZ = 72000000,
  parameter longint AUX_SEL1_HZ = 48000000,
  parameter int     SPREAD_DIV  = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ch2_en,
  input  logic              ch2_sel,
  output logic [INT_W-1:0]  ch1_int,
  output logic [FRAC_W-1:0] ch1_frac,
  output logic [INT_W-1:0]  ch2_int,
  output logic [FRAC_W-1:0] ch2_frac
);

  ssm_channel #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .REF_HZ(REF_HZ), .MOD_HZ(MOD_HZ),
    .F0_HZ(MAIN_HZ), .F1_HZ(MAIN_HZ), .SPREAD_DIV(SPREAD_DIV)
  ) u_main (
    .clk(clk), .rst(rst), .en(1'b1), .sel(1'b0),
    .div_int(ch1_int), .div_frac(ch1_frac)
  );

  ssm_channel #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .REF_HZ(REF_HZ), .MOD_HZ(MOD_HZ),
    .F0_HZ(AUX_SEL0_HZ), .F1_HZ(AUX_SEL1_HZ), .SPREAD_DIV(SPREAD_DIV)
  ) u_aux (
    .clk(clk), .rst(rst), .en(ch2_en), .sel(ch2_sel),
    .div_int(ch2_int), .div_frac(ch2_frac)
  );

endmodule

// File: tb/spread_mod_gen_bench.sv
module spread_mod_gen_bench;
  localparam int     INT_W  = 8;
  localparam int     FRAC_W = 24;
  localparam longint REFF   = 14318180;
  localparam longint MODF   = 40000;
  localparam int     P      = 2 * int'(((REFF + MODF / 2) / MODF) / 2);
  localparam int     H      = P / 2;

  logic clk = 1'b0, rst = 1'b1, ch2_en = 1'b1, ch2_sel = 1'b0;
  logic [INT_W-1:0]  ch1_int, ch2_int;
  logic [FRAC_W-1:0] ch1_frac, ch2_frac;

  always #5 clk = ~clk;

  spread_mod_gen u_spread_mod_gen (
    .clk(clk), .rst(rst), .ch2_en(ch2_en), .ch2_sel(ch2_sel),
    .ch1_int(ch1_int), .ch1_frac(ch1_frac), .ch2_int(ch2_int), .ch2_frac(ch2_frac)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  longint nom1, amp1, q1;
  longint nom2 [2], amp2 [2];
  int i1, i2, cyc = 0, last_min = -1;
  bit s2, started = 0;
  longint prev1;
  longint per [P];

  function automatic longint nomf(longint f);
    return ((f << FRAC_W) + REFF / 2) / REFF;
  endfunction
  function automatic longint ampf(longint n);
    return (n + 50) / 100;
  endfunction
  function automatic longint expv(longint n, longint a, int idx);
    if (idx < H) return n - a + (longint'(idx) * 2 * a) / H;
    return n + a - (longint'(idx - H) * 2 * a) / H;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic analyze_period();
    longint sum = 0, mx = per[0], mn = per[0];
    for (int j = 0; j < P; j++) begin
      sum += per[j];
      if (per[j] > mx) mx = per[j];
      if (per[j] < mn) mn = per[j];
    end
    check("R6 period sum", sum, longint'(P) * nom1);
    check("R2 maximum", mx, nom1 + amp1);
    check("R2 minimum", mn, nom1 - amp1);
    for (int j = 0; j < H; j++)
      check("R5 mirror pair", per[H + j] + per[j], 2 * nom1);
  endtask

  task automatic tick(string tag2);
    bit s_old, rising, ok;
    longint v1, v2, d;
    @(posedge clk);
    cyc++;
    i1 = (i1 + 1) % P;
    s_old = s2;
    if (ch2_en) begin
      i2 = (i2 + 1) % P;
      if (i2 == 0) s2 = ch2_sel;
    end
    @(negedge clk);
    v1 = longint'({ch1_int, ch1_frac});
    v2 = longint'({ch2_int, ch2_frac});
    check("R1 main sample", v1, expv(nom1, amp1, i1));
    check({tag2, " aux sample"}, v2, expv(nom2[s2], amp2[s2], i2));
    if (s2 != s_old) check("R9 first sample after select change", v2, nom2[s2] - amp2[s2]);
    d = v1 - prev1;
    rising = (i1 >= 1 && i1 <= H);
    ok = rising ? (d == q1 || d == q1 + 1) : (-d == q1 || -d == q1 + 1);
    check("R4 step size and direction", longint'(ok), 1);
    prev1 = v1;
    if (v1 == nom1 - amp1) begin
      if (last_min >= 0) check("R3 period length", longint'(cyc - last_min), longint'(P));
      last_min = cyc;
    end
    per[i1] = v1;
    if (i1 == 0) started = 1;
    if (started && i1 == P - 1) analyze_period();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint v;
    nom1 = nomf(120000000);
    amp1 = ampf(nom1);
    q1   = (2 * amp1) / H;
    nom2[0] = nomf(72000000);
    nom2[1] = nomf(48000000);
    amp2[0] = ampf(nom2[0]);
    amp2[1] = ampf(nom2[1]);
    check("R3 half length", longint'(H), 179);
    repeat (3) @(posedge clk);
    @(negedge clk);
    v = longint'({ch1_int, ch1_frac});
    check("R7 main during reset", v, expv(nom1, amp1, (H - 1) / 2));
    rst = 1'b0;
    i1 = (H - 1) / 2;
    i2 = i1;
    s2 = 1'b0;
    v = longint'({ch1_int, ch1_frac});
    check("R7 main after reset", v, expv(nom1, amp1, i1));
    prev1 = v;
    v = longint'({ch2_int, ch2_frac});
    check("R7 aux after reset", v, expv(nom2[0], amp2[0], i2));
    repeat (3 * P) tick("R1");
    ch2_en = 1'b0;
    repeat (60) tick("R8 hold");
    ch2_en = 1'b1;
    repeat (50) tick("R8 resume");
    ch2_sel = 1'b1;
    repeat (2 * P) tick("R9");
    ch2_en = 1'b0;
    ch2_sel = 1'b0;
    repeat (30) tick("R8 hold");
    ch2_en = 1'b1;
    repeat (P + 10) tick("R9");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule